// File: doc/BRIEF.md
# Paged Address Translation Map

This block sits between a bus-mastering network controller, the host, and a bank of on-board RAM. Every memory access arrives as a 24-bit address. A host-written table of 1024 page descriptors turns that address into a physical RAM address, a memory-location select and byte-lane enables. Pages are 1024 bytes. The four top address bits are dropped, so the controller's view and the host's view of memory share one table.

Each descriptor holds a physical frame number, a bit that selects on-board memory or an auxiliary bus, and a byte-order bit. When a page is marked for little-endian controller order, the block swaps the two bytes of a 16-bit access on both the write and the read path. For an 8-bit access to such a page it flips address bit 0 instead. A request is presented for one cycle and its translated form appears on the RAM side after the next clock edge. Several descriptors may name the same frame, so the last descriptor can alias the top-of-space structure area into frame 0.

Top module: `page_xlate_map`

## Requirements
- R1: Request address bits 9:1 appear unchanged as bits 9:1 of `ram_addr_o`. For a 16-bit access, bit 0 also passes unchanged.
- R2: The descriptor is chosen by request address bits 19:10. Bits 23:20 have no effect on any output.
- R3: `ram_addr_o` is the 12-bit frame field (descriptor bits 11:0) followed by the 10-bit offset. It is valid, with `ram_valid_o` high, in the cycle after a request is sampled with `req_valid_i` high. Without a request, `ram_valid_o` is low one cycle later.
- R4: `ram_aux_o` equals bit 13 of the selected descriptor (1 = auxiliary bus, 0 = on-board).
- R5: A 16-bit access (`req_wide_i`=1) enables both lanes (`ram_lane_o`=2'b11). If descriptor bit 15 is 0, the bytes are swapped: `ram_wdata_o`={wdata[7:0],wdata[15:8]} and `rsp_rdata_o`={rdata[7:0],rdata[15:8]}. If bit 15 is 1, both paths pass straight through.
- R6: An 8-bit access uses effective bit 0 = addr[0] XOR NOT(descriptor bit 15). That bit becomes `ram_addr_o[0]`. Lane enable is 2'b01 when the bit is 0 and 2'b10 when it is 1. `ram_wdata_o` carries wdata[7:0] on both bytes. `rsp_rdata_o` returns the selected RAM byte in bits 7:0, with bits 15:8 zero.
- R7: `ram_range_err_o` is 1 when the frame field is 256 or more, and 0 otherwise.
- R8: A descriptor write on one clock edge affects translations sampled from the next edge on. A request sampled on the same edge uses the old value. `map_rdata_o` shows the last value written to the entry at `map_idx_i`.
- R9: Two descriptors naming the same frame give the same physical frame bits, for example entry 1023 and entry 0.
- R10: After reset every descriptor reads 0 and `ram_valid_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| map_wr_i | input | 1 | Write strobe for a descriptor |
| map_idx_i | input | 10 | Descriptor index for write and readback |
| map_wdata_i | input | 16 | Descriptor value to write |
| map_rdata_o | output | 16 | Descriptor at map_idx_i |
| req_valid_i | input | 1 | Translation request present |
| req_addr_i | input | 24 | Controller or host address |
| req_wide_i | input | 1 | 1 = 16-bit access, 0 = 8-bit access |
| req_wdata_i | input | 16 | Write data of the access |
| ram_valid_o | output | 1 | Translated access valid |
| ram_addr_o | output | 22 | Physical address {frame, offset} |
| ram_lane_o | output | 2 | Byte-lane enables, bit 0 = low byte |
| ram_wdata_o | output | 16 | Lane-steered write data |
| ram_aux_o | output | 1 | 1 = auxiliary bus, 0 = on-board |
| ram_range_err_o | output | 1 | Frame beyond installed RAM |
| ram_rdata_i | input | 16 | Read data from RAM for the presented access |
| rsp_rdata_o | output | 16 | Read data steered back to requester order |

## Verification
The assertions assume that `req_wide_i` and the request address stay stable for the sampling edge. They also assume that `ram_rdata_i` belongs to the access currently presented on the RAM side. The bench changes all inputs on the falling edge and leaves `ram_rdata_i` constant while each result is examined. Descriptor writes and requests to the same index are put on the same edge on purpose, to exercise the old-value rule. All other requests go to indices written at least one cycle earlier.

// File: rtl/pxm_pkg.sv
package pxm_pkg;
  localparam int ADDR_W    = 24;
  localparam int OFF_W     = 10;
  localparam int IDX_W     = 10;
  localparam int ENTRY_W   = 16;
  localparam int FRAME_W   = 12;
  localparam int DATA_W    = 16;
  localparam int NUM_LANES = DATA_W / 8;
  localparam int KEEP_W    = OFF_W + IDX_W;
  localparam int PHYS_W    = FRAME_W + OFF_W;
  localparam int ORDER_BIT = 15;
  localparam int AUX_BIT   = 13;

  typedef struct packed {
    logic               big_end;
    logic               aux;
    logic [FRAME_W-1:0] frame;
  } desc_t;

  function automatic desc_t decode_desc(input logic [ENTRY_W-1:0] e);
    desc_t d;
    d.big_end = e[ORDER_BIT];
    d.aux     = e[AUX_BIT];
    d.frame   = e[FRAME_W-1:0];
    return d;
  endfunction
endpackage

// File: rtl/pxm_map_store.sv
module pxm_map_store
  import pxm_pkg::*;
#(
  parameter int DEPTH = 1 << IDX_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_i,
  input  logic [IDX_W-1:0]   widx_i,
  input  logic [ENTRY_W-1:0] wdata_i,
  input  logic [IDX_W-1:0]   host_idx_i,
  output logic [ENTRY_W-1:0] host_rdata_o,
  input  logic [IDX_W-1:0]   xl_idx_i,
  output logic [ENTRY_W-1:0] xl_rdata_o
);
  logic [ENTRY_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (wr_i) begin
      mem_q[widx_i] <= wdata_i;
    end
  end

  assign host_rdata_o = mem_q[host_idx_i];
  assign xl_rdata_o   = mem_q[xl_idx_i];

  AST_MAP_WRITE_LANDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> mem_q[$past(widx_i)] == $past(wdata_i)); // R8
endmodule

// File: rtl/pxm_wr_steer.sv
module pxm_wr_steer
  import pxm_pkg::*;
(
  input  logic                 wide_i,
  input  logic                 big_end_i,
  input  logic                 addr0_i,
  input  logic [DATA_W-1:0]    wdata_i,
  output logic                 eff_a0_o,
  output logic [NUM_LANES-1:0] lane_o,
  output logic [DATA_W-1:0]    wdata_o
);
  // little-endian pages: narrow accesses flip a0, wide ones swap lanes
  assign eff_a0_o = wide_i ? addr0_i : (addr0_i ^ ~big_end_i);

  for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
    localparam int SWP = g ^ 1;
    logic [7:0] wide_byte;
    assign wide_byte     = big_end_i ? wdata_i[g*8 +: 8] : wdata_i[SWP*8 +: 8];
    assign lane_o[g]     = wide_i | (eff_a0_o == 1'(g));
    assign wdata_o[g*8 +: 8] = wide_i ? wide_byte : wdata_i[7:0];
  end
endmodule

// File: rtl/pxm_rd_steer.sv
module pxm_rd_steer
  import pxm_pkg::*;
(
  input  logic              wide_i,
  input  logic              big_end_i,
  input  logic              hi_lane_i,
  input  logic [DATA_W-1:0] rdata_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [7:0] narrow_byte;
  assign narrow_byte = hi_lane_i ? rdata_i[15:8] : rdata_i[7:0];

  for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
    localparam int SWP = g ^ 1;
    logic [7:0] wide_byte;
    assign wide_byte = big_end_i ? rdata_i[g*8 +: 8] : rdata_i[SWP*8 +: 8];
    if (g == 0) begin : g_low
      assign rdata_o[7:0] = wide_i ? wide_byte : narrow_byte;
    end else begin : g_up
      assign rdata_o[g*8 +: 8] = wide_i ? wide_byte : 8'h00;
    end
  end
endmodule

// File: rtl/pxm_xlate_stage.sv
module pxm_xlate_stage
  import pxm_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 valid_i,
  input  logic [PHYS_W-1:0]    addr_i,
  input  logic [NUM_LANES-1:0] lane_i,
  input  logic [DATA_W-1:0]    wdata_i,
  input  logic                 aux_i,
  input  logic                 err_i,
  input  logic                 wide_i,
  input  logic                 big_end_i,
  output logic                 valid_o,
  output logic [PHYS_W-1:0]    addr_o,
  output logic [NUM_LANES-1:0] lane_o,
  output logic [DATA_W-1:0]    wdata_o,
  output logic                 aux_o,
  output logic                 err_o,
  output logic                 wide_o,
  output logic                 big_end_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o   <= 1'b0;
      addr_o    <= '0;
      lane_o    <= '0;
      wdata_o   <= '0;
      aux_o     <= 1'b0;
      err_o     <= 1'b0;
      wide_o    <= 1'b0;
      big_end_o <= 1'b0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        addr_o    <= addr_i;
        lane_o    <= lane_i;
        wdata_o   <= wdata_i;
        aux_o     <= aux_i;
        err_o     <= err_i;
        wide_o    <= wide_i;
        big_end_o <= big_end_i;
      end
    end
  end

  AST_VALID_TRACKS_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o); // R3
  AST_IDLE_TRACKS_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o); // R3
  AST_WIDE_BOTH_LANES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && wide_o) |-> lane_o == '1); // R5
  AST_NARROW_ONE_LANE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !wide_o) |-> $onehot(lane_o)); // R6
  AST_NARROW_LANE_A0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !wide_o) |-> lane_o[1] == addr_o[0]); // R6
endmodule

// File: rtl/page_xlate_map.sv
module page_xlate_map
  import pxm_pkg::*;
#(
  parameter int NUM_FRAMES = 256
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               map_wr_i,
  input  logic [IDX_W-1:0]   map_idx_i,
  input  logic [ENTRY_W-1:0] map_wdata_i,
  output logic [ENTRY_W-1:0] map_rdata_o,
  input  logic               req_valid_i,
  input  logic [ADDR_W-1:0]  req_addr_i,
  input  logic               req_wide_i,
  input  logic [DATA_W-1:0]  req_wdata_i,
  output logic               ram_valid_o,
  output logic [PHYS_W-1:0]  ram_addr_o,
  output logic [1:0]         ram_lane_o,
  output logic [DATA_W-1:0]  ram_wdata_o,
  output logic               ram_aux_o,
  output logic               ram_range_err_o,
  input  logic [DATA_W-1:0]  ram_rdata_i,
  output logic [DATA_W-1:0]  rsp_rdata_o
);
  localparam logic [FRAME_W:0] FRAME_LIMIT = (FRAME_W+1)'(NUM_FRAMES);

  // top address bits are dropped here
  logic [KEEP_W-1:0]    addr_kept;
  logic [IDX_W-1:0]     xl_idx;
  logic [ENTRY_W-1:0]   xl_entry;
  desc_t                desc;
  logic                 eff_a0;
  logic [NUM_LANES-1:0] lane_d;
  logic [DATA_W-1:0]    wdata_d;
  logic [PHYS_W-1:0]    phys_d;
  logic                 err_d;
  logic                 wide_q;
  logic                 big_end_q;

  assign addr_kept = KEEP_W'(req_addr_i);
  assign xl_idx    = addr_kept[KEEP_W-1:OFF_W];
  assign desc      = decode_desc(xl_entry);
  assign phys_d    = {desc.frame, addr_kept[OFF_W-1:1], eff_a0};
  assign err_d     = {1'b0, desc.frame} >= FRAME_LIMIT;

  pxm_map_store u_store (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .wr_i         (map_wr_i),
    .widx_i       (map_idx_i),
    .wdata_i      (map_wdata_i),
    .host_idx_i   (map_idx_i),
    .host_rdata_o (map_rdata_o),
    .xl_idx_i     (xl_idx),
    .xl_rdata_o   (xl_entry)
  );

  pxm_wr_steer u_wr_steer (
    .wide_i    (req_wide_i),
    .big_end_i (desc.big_end),
    .addr0_i   (addr_kept[0]),
    .wdata_i   (req_wdata_i),
    .eff_a0_o  (eff_a0),
    .lane_o    (lane_d),
    .wdata_o   (wdata_d)
  );

  pxm_xlate_stage u_stage (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .valid_i   (req_valid_i),
    .addr_i    (phys_d),
    .lane_i    (lane_d),
    .wdata_i   (wdata_d),
    .aux_i     (desc.aux),
    .err_i     (err_d),
    .wide_i    (req_wide_i),
    .big_end_i (desc.big_end),
    .valid_o   (ram_valid_o),
    .addr_o    (ram_addr_o),
    .lane_o    (ram_lane_o),
    .wdata_o   (ram_wdata_o),
    .aux_o     (ram_aux_o),
    .err_o     (ram_range_err_o),
    .wide_o    (wide_q),
    .big_end_o (big_end_q)
  );

  pxm_rd_steer u_rd_steer (
    .wide_i    (wide_q),
    .big_end_i (big_end_q),
    .hi_lane_i (ram_lane_o[1]),
    .rdata_i   (ram_rdata_i),
    .rdata_o   (rsp_rdata_o)
  );

  AST_OFFSET_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ram_valid_o |-> ram_addr_o[OFF_W-1:1] == $past(req_addr_i[OFF_W-1:1])); // R1
  AST_RANGE_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ram_valid_o |-> ram_range_err_o == ({1'b0, ram_addr_o[PHYS_W-1:OFF_W]} >= FRAME_LIMIT)); // R7
endmodule

// File: tb/page_xlate_map_tb.sv
`timescale 1ns/1ps
module page_xlate_map_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        map_wr_i = 1'b0;
  logic [9:0]  map_idx_i = '0;
  logic [15:0] map_wdata_i = '0;
  logic [15:0] map_rdata_o;
  logic        req_valid_i = 1'b0;
  logic [23:0] req_addr_i = '0;
  logic        req_wide_i = 1'b0;
  logic [15:0] req_wdata_i = '0;
  logic        ram_valid_o;
  logic [21:0] ram_addr_o;
  logic [1:0]  ram_lane_o;
  logic [15:0] ram_wdata_o;
  logic        ram_aux_o;
  logic        ram_range_err_o;
  logic [15:0] ram_rdata_i = 16'h5A3C;
  logic [15:0] rsp_rdata_o;

  int checks = 0;
  int failures = 0;
  logic [15:0] shadow [1024];

  always #2.5 clk_i = ~clk_i;

  page_xlate_map u_dut (.*);

  // {addr, wide, wdata}
  localparam logic [40:0] VEC [11] = '{
    {24'h000010, 1'b1, 16'h1234},
    {24'hFFFFF4, 1'b1, 16'hABCD},
    {24'hF00010, 1'b1, 16'h1234},
    {24'h001402, 1'b1, 16'hBEEF},
    {24'h001403, 1'b0, 16'h0077},
    {24'h001404, 1'b0, 16'h00C3},
    {24'h001BFE, 1'b1, 16'h0102},
    {24'h001801, 1'b0, 16'h0099},
    {24'h001C00, 1'b1, 16'h4455},
    {24'h002000, 1'b0, 16'h00E1},
    {24'h5023FF, 1'b0, 16'h0042}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic map_write(input logic [9:0] idx, input logic [15:0] val);
    @(negedge clk_i);
    map_wr_i = 1'b1; map_idx_i = idx; map_wdata_i = val;
    @(negedge clk_i);
    map_wr_i = 1'b0;
    shadow[idx] = val;
  endtask

  task automatic send_check(input logic [23:0] a, input logic w, input logic [15:0] d);
    logic [15:0] e;
    logic big, e0;
    logic [21:0] exp_addr;
    logic [1:0]  exp_lane;
    logic [15:0] exp_wd, exp_rd;
    e   = shadow[a[19:10]];
    big = e[15];
    e0  = w ? a[0] : (a[0] ^ ~big);
    exp_addr = {e[11:0], a[9:1], e0};
    exp_lane = w ? 2'b11 : (e0 ? 2'b10 : 2'b01);
    exp_wd   = w ? (big ? d : {d[7:0], d[15:8]}) : {d[7:0], d[7:0]};
    exp_rd   = w ? (big ? ram_rdata_i : {ram_rdata_i[7:0], ram_rdata_i[15:8]})
                 : {8'h00, (e0 ? ram_rdata_i[15:8] : ram_rdata_i[7:0])};
    @(negedge clk_i);
    req_valid_i = 1'b1; req_addr_i = a; req_wide_i = w; req_wdata_i = d;
    @(negedge clk_i);
    req_valid_i = 1'b0;
    chk("R3 valid", 32'(ram_valid_o), 32'd1);
    chk("R1 R2 R3 addr", 32'(ram_addr_o), 32'(exp_addr));
    chk("R5 R6 lane", 32'(ram_lane_o), 32'(exp_lane));
    chk("R5 R6 wdata", 32'(ram_wdata_o), 32'(exp_wd));
    chk("R5 R6 rdata", 32'(rsp_rdata_o), 32'(exp_rd));
    chk("R4 aux", 32'(ram_aux_o), 32'(e[13]));
    chk("R7 range", 32'(ram_range_err_o), 32'(e[11:0] >= 12'd256));
  endtask

  initial begin
    #200000;
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int i = 0; i < 1024; i++) shadow[i] = 16'h0000;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    map_idx_i = 10'd3;
    @(negedge clk_i);
    // R10 reset state
    chk("R10 valid", 32'(ram_valid_o), 32'd0);
    chk("R10 map", 32'(map_rdata_o), 32'd0);

    map_write(10'd0,    16'h8000);
    map_write(10'd1023, 16'h8000);
    map_write(10'd5,    16'h0023);
    map_write(10'd6,    16'hA0FF);
    map_write(10'd7,    16'h0100);
    map_write(10'd8,    16'h20A5);

    for (int v = 0; v < 11; v++)
      send_check(VEC[v][40:17], VEC[v][16], VEC[v][15:0]);

    // R9 alias: entry 1023 and entry 0 both reach frame 0
    send_check(24'hFFFFF4, 1'b1, 16'h0000);
    chk("R9 alias hi", 32'(ram_addr_o[21:10]), 32'd0);
    send_check(24'h0003F4, 1'b1, 16'h0000);
    chk("R9 alias lo", 32'(ram_addr_o), 32'h3F4);

    // R3 no request -> valid low
    @(negedge clk_i);
    chk("R3 idle", 32'(ram_valid_o), 32'd0);

    // R8 same-edge write and request: old value used
    @(negedge clk_i);
    map_wr_i = 1'b1; map_idx_i = 10'd9; map_wdata_i = 16'h8011;
    req_valid_i = 1'b1; req_addr_i = 24'h002404; req_wide_i = 1'b1; req_wdata_i = 16'h1122;
    @(negedge clk_i);
    map_wr_i = 1'b0; req_valid_i = 1'b0;
    shadow[9] = 16'h8011;
    chk("R8 old frame", 32'(ram_addr_o[21:10]), 32'd0);
    chk("R8 old order", 32'(ram_wdata_o), 32'h2211);
    chk("R8 readback", 32'(map_rdata_o), 32'h8011);
    send_check(24'h002404, 1'b1, 16'h1122);
    chk("R8 new frame", 32'(ram_addr_o[21:10]), 32'h011);

    // R10 reset again clears descriptors
    @(negedge clk_i);
    rst_ni = 1'b0;
    @(negedge clk_i);
    rst_ni = 1'b1;
    map_idx_i = 10'd6;
    @(negedge clk_i);
    chk("R10 map cleared", 32'(map_rdata_o), 32'd0);
    chk("R10 valid cleared", 32'(ram_valid_o), 32'd0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule